// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block runs eight digital pins from a small register bus. Software uses it to set which pins drive and which pins listen. It reads the synchronized pin levels and takes interrupts or wakeup requests from pin edges. One data register does two jobs. For a pin that drives, each data bit sets the level on that pin. For a pin that listens, the same bit turns the weak pullup on that pin on or off. Changing a pin's direction never changes the stored data bits.

After reset, the low four pins belong to a test access port: pin 0 carries test data out, and pins 1, 2 and 3 carry mode select, data in and test clock. A control bit hands those four pins back to the port. The upper four pins come out of reset as inputs with pullups on. Every pin has an edge detector with a selectable polarity, an enable bit and a sticky flag. A single interrupt line collects the enabled flags.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The data register (address 0) reads 16 bits. Bits 7..0 reset to 0xFF. Bits 15..8 always read 0 and writes to them have no effect.
- R2: After reset, the other registers read as follows. Direction (address 1, 1 = drive) is 0x00. Control (address 3, bit 0 = test port owns pins 0..3) is 0x0001. Edge select (address 4), interrupt enable (address 5) and flags (address 6) are all 0. Address 7 always reads 0.
- R3: A read of the data register returns the stored value and not the pin levels. A write to the direction register leaves the data register unchanged.
- R4: A port-owned pin whose direction bit is 1 drives: pin_oe is 1, pin_out equals its data bit, and pin_pullup is 0.
- R5: A port-owned pin whose direction bit is 0 listens: pin_oe is 0, pin_out is 0, and pin_pullup equals its data bit.
- R6: While control bit 0 is set, pins 0..3 ignore the direction and data registers. Pin 0 drives jtag_tdo with enable jtag_tdo_oe. Pins 1..3 never drive. All four have pullup 0. jtag_tms, jtag_tdi and jtag_tck follow pin_in[1], pin_in[2] and pin_in[3].
- R7: Writing 0 to control bit 0 gives pins 0..3 to the direction and data registers, as in R4 and R5.
- R8: The input register (address 2) returns pin_in through a two-flop synchronizer. A pin change set up before clock edge k is visible in a read after edge k+1, and not after edge k.
- R9: A pin's flag (bit i of address 6) sets on the selected edge of its synchronized level: edge-select bit 0 means rising and 1 means falling. The flag is set after the third clock edge from the pin change. The other edge does not set it.
- R10: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it as it was.
- R11: irq is 1 exactly when some flag bit and the matching enable bit are both 1. It follows the flags with no added cycle.
- R12: The input register is read-only, and writes to address 2 do not change what it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_pullup | output | 8 | Weak pullup enables |
| pin_level | output | 8 | Synchronized pin levels for on-chip peripherals |
| jtag_tdo | input | 1 | Test data out from the test access port |
| jtag_tdo_oe | input | 1 | Drive enable for test data out |
| jtag_tms | output | 1 | Mode select to the test access port |
| jtag_tdi | output | 1 | Test data in to the test access port |
| jtag_tck | output | 1 | Test clock to the test access port |
| irq | output | 1 | Combined interrupt and wakeup request |

## Verification
Register writes take effect at the clock edge that samples the strobe. Pin controls and read data follow with no further cycle, so the bench checks them at the next falling edge. The input register lags a pin change by two edges, and flags and irq lag it by three. The bench changes pins at a falling edge and counts exactly that many rising edges before it samples. For R8 it also samples one edge early to confirm the old value is still held.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_LEVEL = 3'd2,
    REG_CTRL  = 3'd3,
    REG_EDGE  = 3'd4,
    REG_IE    = 3'd5,
    REG_FLAG  = 3'd6,
    REG_VOID  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N_PINS-1:0] level,
  input  logic [N_PINS-1:0] flags,
  output logic [BUS_W-1:0]  rdata,
  output logic [N_PINS-1:0] data_q,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] edge_q,
  output logic [N_PINS-1:0] ie_q,
  output logic              own_q,
  output logic [N_PINS-1:0] flag_clr
);
  localparam logic [N_PINS-1:0] DATA_RST = {N_PINS{1'b1}};

  logic [N_PINS-1:0] data_d, dir_d, edge_d, ie_d;
  logic              own_d;
  reg_addr_e         sel;

  assign sel = reg_addr_e'(addr);

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    edge_d = edge_q;
    ie_d   = ie_q;
    own_d  = own_q;
    if (wr) begin
      unique case (sel)
        REG_DATA: data_d = wdata[N_PINS-1:0];
        REG_DIR:  dir_d  = wdata[N_PINS-1:0];
        REG_CTRL: own_d  = wdata[0];
        REG_EDGE: edge_d = wdata[N_PINS-1:0];
        REG_IE:   ie_d   = wdata[N_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      dir_q  <= '0;
      edge_q <= '0;
      ie_q   <= '0;
      own_q  <= 1'b1;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      edge_q <= edge_d;
      ie_q   <= ie_d;
      own_q  <= own_d;
    end
  end

  assign flag_clr = (wr && sel == REG_FLAG) ? wdata[N_PINS-1:0] : '0;

  always_comb begin
    rdata = '0;
    unique case (sel)
      REG_DATA:  rdata[N_PINS-1:0] = data_q;
      REG_DIR:   rdata[N_PINS-1:0] = dir_q;
      REG_LEVEL: rdata[N_PINS-1:0] = level;
      REG_CTRL:  rdata[0]          = own_q;
      REG_EDGE:  rdata[N_PINS-1:0] = edge_q;
      REG_IE:    rdata[N_PINS-1:0] = ie_q;
      REG_FLAG:  rdata[N_PINS-1:0] = flags;
      default:   ;
    endcase
  end

  // R1: only the low byte of a data write lands, whatever the upper bits carry
  assert_data_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_DATA && |wdata[BUS_W-1:N_PINS]) |=> data_q == $past(wdata[N_PINS-1:0]));

  // R3: a direction write leaves stored data untouched
  assert_dir_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_DIR) |=> $stable(data_q));

  // R12: writes to the level address change no register
  assert_level_readonly_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_LEVEL) |=> ($stable(data_q) && $stable(dir_q) && $stable(ie_q)));
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] edge_sel,
  input  logic [N_PINS-1:0] flag_clr,
  output logic [N_PINS-1:0] level,
  output logic [N_PINS-1:0] flags
);
  localparam int unsigned WARM_MAX = SYNC_STAGES + 1;
  localparam int unsigned WARM_W   = $clog2(WARM_MAX + 1);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(WARM_MAX);

  logic [N_PINS-1:0] sync_q [SYNC_STAGES];
  logic [N_PINS-1:0] prev_q, flag_q, flag_d, hit;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign armed = (warm_q == WARM_DONE);
  assign warm_d = armed ? warm_q : warm_q + 1'b1;

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      always_comb begin
        hit[i] = 1'b0;
        if (armed) begin
          if (edge_sel[i]) hit[i] = prev_q[i] & ~level[i];
          else             hit[i] = level[i] & ~prev_q[i];
        end
        flag_d[i] = (flag_q[i] & ~flag_clr[i]) | hit[i];
      end

      // R9: a flag only rises after a detected edge of the selected kind
      assert_flag_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(hit[i]));

      // R10: a flag only drops after a write of 1 to its bit
      assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[i]) |-> $past(flag_clr[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= level;
      flag_q <= flag_d;
      warm_q <= warm_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned N_TEST = 4
) (
  input  logic [N_PINS-1:0] data_q,
  input  logic [N_PINS-1:0] dir_q,
  input  logic              own_q,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              jtag_tdo,
  input  logic              jtag_tdo_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_pullup,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  output logic              jtag_tck
);
  localparam int unsigned TDO_IDX = 0;
  localparam int unsigned TMS_IDX = 1;
  localparam int unsigned TDI_IDX = 2;
  localparam int unsigned TCK_IDX = 3;

  logic [N_PINS-1:0] gp_out, gp_oe, gp_pu;

  assign gp_oe  = dir_q;
  assign gp_out = data_q & dir_q;
  assign gp_pu  = data_q & ~dir_q;

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      if (i >= N_TEST) begin : g_plain
        assign pin_out[i]    = gp_out[i];
        assign pin_oe[i]     = gp_oe[i];
        assign pin_pullup[i] = gp_pu[i];
      end else if (i == TDO_IDX) begin : g_tdo
        assign pin_out[i]    = own_q ? jtag_tdo    : gp_out[i];
        assign pin_oe[i]     = own_q ? jtag_tdo_oe : gp_oe[i];
        assign pin_pullup[i] = own_q ? 1'b0        : gp_pu[i];
      end else begin : g_test_in
        assign pin_out[i]    = own_q ? 1'b0 : gp_out[i];
        assign pin_oe[i]     = own_q ? 1'b0 : gp_oe[i];
        assign pin_pullup[i] = own_q ? 1'b0 : gp_pu[i];
      end
    end
  endgenerate

  assign jtag_tms = pin_in[TMS_IDX];
  assign jtag_tdi = pin_in[TDI_IDX];
  assign jtag_tck = pin_in[TCK_IDX];
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned N_TEST      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_pullup,
  output logic [N_PINS-1:0] pin_level,
  input  logic              jtag_tdo,
  input  logic              jtag_tdo_oe,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  output logic              jtag_tck,
  output logic              irq
);
  logic              rst_meta_q, rst_sync_q;
  logic [N_PINS-1:0] data_q, dir_q, edge_q, ie_q, flag_clr, flags, level;
  logic              own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpio_regs #(.N_PINS(N_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .level    (level),
    .flags    (flags),
    .rdata    (bus_rdata),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .edge_q   (edge_q),
    .ie_q     (ie_q),
    .own_q    (own_q),
    .flag_clr (flag_clr)
  );

  gpio_edge_unit #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pin_in   (pin_in),
    .edge_sel (edge_q),
    .flag_clr (flag_clr),
    .level    (level),
    .flags    (flags)
  );

  gpio_pin_mux #(.N_PINS(N_PINS), .N_TEST(N_TEST)) u_mux (
    .data_q      (data_q),
    .dir_q       (dir_q),
    .own_q       (own_q),
    .pin_in      (pin_in),
    .jtag_tdo    (jtag_tdo),
    .jtag_tdo_oe (jtag_tdo_oe),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_pullup  (pin_pullup),
    .jtag_tms    (jtag_tms),
    .jtag_tdi    (jtag_tdi),
    .jtag_tck    (jtag_tck)
  );

  assign pin_level = level;
  assign irq = |(flags & ie_q);

  // R11: with every enable clear, no request leaves the block
  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(|ie_q) |-> !irq);

  // R6: test-owned pins stay undriven unless the port asks for test data out
  assert_test_pins_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (own_q && !jtag_tdo_oe) |-> (pin_oe[N_TEST-1:0] == '0 && pin_pullup[N_TEST-1:0] == '0));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic        clk, rst_n, bus_wr, jtag_tdo, jtag_tdo_oe;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, pin_pullup, pin_level;
  logic        jtag_tms, jtag_tdi, jtag_tck, irq;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .pin_level(pin_level), .jtag_tdo(jtag_tdo), .jtag_tdo_oe(jtag_tdo_oe),
    .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tck(jtag_tck), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 8'hF0; jtag_tdo = 1'b0; jtag_tdo_oe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Reset state
    rd(3'd0, r); chk("R1", "data reset", r, 16'h00FF);
    rd(3'd1, r); chk("R2", "dir reset", r, 16'h0000);
    rd(3'd3, r); chk("R2", "ctrl reset", r, 16'h0001);
    rd(3'd4, r); chk("R2", "edge reset", r, 16'h0000);
    rd(3'd5, r); chk("R2", "ie reset", r, 16'h0000);
    rd(3'd6, r); chk("R2", "flag reset", r, 16'h0000);
    rd(3'd7, r); chk("R2", "void read", r, 16'h0000);
    chk("R5", "upper pins reset pullup", pin_pullup[7:4], 4'hF);
    chk("R5", "upper pins reset oe", pin_oe[7:4], 4'h0);
    chk("R6", "test pins reset pullup", pin_pullup[3:0], 4'h0);
    chk("R11", "irq reset", irq, 1'b0);

    // R1 upper byte ignored
    wr(3'd0, 16'hA55A);
    rd(3'd0, r); chk("R1", "upper byte write", r, 16'h005A);
    wr(3'd7, 16'hFFFF);
    rd(3'd7, r); chk("R2", "void after write", r, 16'h0000);

    // R6: test port owns pins 0..3
    wr(3'd1, 16'h00FF);
    wr(3'd0, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      jtag_tdo = k[0]; jtag_tdo_oe = k[1];
      pin_in = 8'(k * 29 + 5);
      #1;
      chk("R6", "pin oe low nibble", pin_oe[3:0], {3'b000, jtag_tdo_oe});
      chk("R6", "pin out low nibble", pin_out[3:0], {3'b000, jtag_tdo});
      chk("R6", "pullup low nibble", pin_pullup[3:0], 4'h0);
      chk("R6", "tap inputs", {jtag_tms, jtag_tdi, jtag_tck}, {pin_in[1], pin_in[2], pin_in[3]});
      chk("R4", "upper pins drive", {pin_oe[7:4], pin_out[7:4]}, 8'hF0);
    end
    jtag_tdo_oe = 1'b0;

    // R7: hand pins back
    wr(3'd3, 16'h0000);
    rd(3'd3, r); chk("R7", "ctrl cleared", r, 16'h0000);
    chk("R7", "low pins follow dir", pin_oe, 8'hFF);
    chk("R7", "low pins follow data", pin_out, 8'h00);

    // R3/R4/R5 exhaustive direction sweep
    for (int d = 0; d < 256; d++) begin
      logic [7:0] o;
      o = 8'((d * 7 + 3) & 255);
      wr(3'd0, {8'h00, o});
      wr(3'd1, {8'h00, 8'(d)});
      rd(3'd0, r); chk("R3", "data kept after dir write", r, {8'h00, o});
      chk("R4", "oe and out", {pin_oe, pin_out}, {8'(d), o & 8'(d)});
      chk("R5", "pullup", pin_pullup, o & ~8'(d));
    end
    wr(3'd0, 16'h0033);
    pin_in = 8'hCC;
    repeat (3) @(negedge clk);
    rd(3'd0, r); chk("R3", "data read not pins", r, 16'h0033);

    // R8 / R12 input sync
    wr(3'd1, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] oldp, newp;
      oldp = pin_in;
      newp = 8'(k * 37 + 11);
      @(negedge clk); pin_in = newp;
      @(negedge clk); rd(3'd2, r); chk("R8", "level one edge", r, {8'h00, oldp});
      @(negedge clk); rd(3'd2, r); chk("R8", "level two edges", r, {8'h00, newp});
    end
    wr(3'd2, 16'h00FF);
    rd(3'd2, r); chk("R12", "level after write", r, {8'h00, pin_in});

    // R9 / R10 / R11 per pin, both polarities
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] m;
        m = 8'(1 << i);
        @(negedge clk); pin_in = 8'h00;
        repeat (4) @(negedge clk);
        wr(3'd4, s ? {8'h00, m} : 16'h0000);
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'h00FF);
        rd(3'd6, r); chk("R10", "flags cleared", r, 16'h0000);
        pin_in = m;
        repeat (2) @(posedge clk);
        @(negedge clk); rd(3'd6, r); chk("R9", "flag after two edges", r, 16'h0000);
        @(negedge clk); rd(3'd6, r); chk("R9", "flag after rise", r, s ? 16'h0000 : {8'h00, m});
        pin_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rd(3'd6, r); chk("R9", "flag after fall", r, {8'h00, m});
        chk("R11", "irq disabled", irq, 1'b0);
        wr(3'd5, {8'h00, ~m});
        chk("R11", "irq other enables", irq, 1'b0);
        wr(3'd5, {8'h00, m});
        chk("R11", "irq enabled", irq, 1'b1);
        wr(3'd6, {8'h00, ~m});
        rd(3'd6, r); chk("R10", "write 0 keeps flag", r, {8'h00, m});
        wr(3'd6, {8'h00, m});
        rd(3'd6, r); chk("R10", "write 1 clears flag", r, 16'h0000);
        chk("R11", "irq after clear", irq, 1'b0);
      end
    end

    finish_run();
  end
endmodule